// File: doc/BRIEF.md
# Random Word Source Register Front-End

This block puts a small bus-addressed register set in front of a pseudo-random word generator. Software enables generation, sets up the source through configuration fields that take effect only on a conditioning-reset write, and pulls 32-bit words one at a time from a shallow output queue. The entropy source is a seedable 32-bit Galois LFSR. The LFSR is reseeded each time a conditioning reset completes, and a programmable power-of-two divider sets how often it runs.

Two fault inputs stand in for the analog monitors. A seed fault stops generation, empties the queue, raises a live flag and a sticky flag, and makes the data register read as zero. Recovery takes one of two paths, chosen by a parameter. In the first, the block restarts itself after a fixed delay and leaves the sticky flag for software to clear. In the second, the live flag stays set until software runs a conditioning reset. A clock fault is only reported, and only when clock-error detection is enabled.

The bus is a single-cycle request (`bus_sel`, `bus_wr`, byte address, write data). A read result appears on `bus_rdata` one clock after the request and holds until the next read.

Top module: `rand_src_front`

## Requirements
- R1: After `rst`, the control register (0x00), status register (0x04), data register (0x08), noise register (0x0C) and health register (0x10) all read 0. An address outside the map reads 0.
- R2: The noise register keeps only its low 18 bits. The health register keeps all 32 bits.
- R3: The configuration bits are clock-error-detect (bit 5), bits 25:8 (including the divider exponent at 19:16) and lock (bit 31). They are captured only by a control write with bit 30 set. On any other control write they are ignored. Enable (bit 2) is taken from every control write.
- R4: Control bit 30 reads 1 from the write that sets it until COND_CYCLES clocks after the next control write with bit 30 clear, and then clears itself. The noise and health registers accept writes only while bit 30 reads 1.
- R5: Once lock (bit 31) is captured, no later write changes the configuration bits, the lock, or the noise and health registers until `rst`. Enable and the conditioning reset still work.
- R6: The generator is a right-shifting Galois LFSR with mask 0xB4BCD35C. Each stored word is the next state. The state is 1 after `rst`. When a conditioning reset completes, the state is reseeded to (health XOR noise) OR 1. Words are delivered in the order they were produced.
- R7: A data read returns the oldest word and removes it. Status bit 0 (ready) is 1 while a word is queued and no seed fault is live. A data read while not ready returns 0.
- R8: A rising edge on `seed_fault` sets status bit 2 (live seed fault) and bit 6 (sticky seed fault), clears ready, discards all queued words, and stops generation. A data read then returns 0.
- R9: With AUTO_RECOVER = 0, bit 2 stays set until a conditioning reset completes. Completion clears bits 2 and 6 and reseeds the generator.
- R10: With AUTO_RECOVER = 1, bit 2 clears AUTO_CYCLES clocks after the fault and generation resumes. Bit 6 stays set until software writes it to 0.
- R11: A status write with 0 in bit 5 or bit 6 clears that flag. A 1 leaves it unchanged. All other status bits ignore writes.
- R12: With bit 5 of control set, status bit 1 follows `clk_fault` (one register late) and bit 5 latches it. With bit 5 of control clear, neither bit is raised.
- R13: The generator advances at most once every 2^D clocks, where D is control bits 19:16. Its prescaler restarts when a conditioning reset completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, held until the next read |
| seed_fault | input | 1 | Injected seed fault (rising edge acts) |
| clk_fault | input | 1 | Injected clock fault level |

## Verification
The bench builds two copies of the block. Both use a 4-word queue, a 6-clock conditioning reset and a 10-clock automatic restart, so the queue fills and every recovery finishes within a few dozen clocks. The first copy uses AUTO_RECOVER = 0. It covers the held fault, recovery by conditioning reset, the lock and a divider exponent of 4. An exponent of 4 makes the ready delay after reseeding long enough to observe. The second copy uses AUTO_RECOVER = 1. It covers the self-restart and the sticky flag that remains set afterwards.

// File: rtl/rng_front_pkg.sv
package rng_front_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int NOISE_W = 18;
  localparam int DIV_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] A_STAT  = 5'h04;
  localparam logic [ADDR_W-1:0] A_DATA  = 5'h08;
  localparam logic [ADDR_W-1:0] A_NOISE = 5'h0C;
  localparam logic [ADDR_W-1:0] A_HTEST = 5'h10;

  localparam int B_EN    = 2;
  localparam int B_CED   = 5;
  localparam int B_DIV   = 16;
  localparam int B_CRST  = 30;
  localparam int B_LOCK  = 31;
  localparam int S_RDY   = 0;
  localparam int S_CLIVE = 1;
  localparam int S_SLIVE = 2;
  localparam int S_CSTKY = 5;
  localparam int S_SSTKY = 6;

  // configuration bits captured with the conditioning reset (lock included)
  localparam logic [DATA_W-1:0] CFG_MASK = 32'h83FF_FF20;

  localparam logic [DATA_W-1:0] LFSR_POLY  = 32'hB4BC_D35C;
  localparam logic [DATA_W-1:0] RESET_SEED = 32'h0000_0001;

  typedef enum logic [2:0] {
    SQ_RUN,
    SQ_ARMED,
    SQ_CLEAN,
    SQ_FAULT,
    SQ_AUTO
  } seq_state_e;

  function automatic logic [DATA_W-1:0] lfsr_step(input logic [DATA_W-1:0] s);
    return s[0] ? ((s >> 1) ^ LFSR_POLY) : (s >> 1);
  endfunction
endpackage

// File: rtl/rng_lfsr_gen.sv
module rng_lfsr_gen
  import rng_front_pkg::*;
#(
  parameter int W = DATA_W,
  parameter int DW = DIV_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [DW-1:0] div_exp,
  input  logic         reseed,
  input  logic [W-1:0] seed,
  input  logic         allow,
  input  logic         room,
  output logic         push,
  output logic [W-1:0] word
);
  localparam int PRE_W = (1 << DW) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_mask;
  logic [W-1:0]     state_q;
  logic             tick;

  always_comb begin
    pre_mask = {PRE_W{1'b1}} >> (PRE_W - int'(div_exp));
    tick     = (pre_q & pre_mask) == pre_mask;
    push     = tick && allow && room && !reseed;
    word     = lfsr_step(state_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q   <= '0;
      state_q <= W'(RESET_SEED);
    end else if (reseed) begin
      pre_q   <= '0;
      state_q <= seed;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (push) state_q <= word;
    end
  end
endmodule

// File: rtl/rng_word_fifo.sv
module rng_word_fifo #(
  parameter int W = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = cnt_q == '0;
  assign full    = cnt_q == CW'(DEPTH);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rp_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= bump(wp_q);
      if (do_pop)  rp_q <= bump(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/rng_seq_ctrl.sv
module rng_seq_ctrl
  import rng_front_pkg::*;
#(
  parameter int COND_CYCLES = 16,
  parameter int AUTO_CYCLES = 32,
  parameter bit AUTO_RECOVER = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic crst_set,
  input  logic crst_clr,
  input  logic seed_evt,
  output logic busy,
  output logic run,
  output logic secs,
  output logic seed_hit,
  output logic reseed
);
  localparam int MAXC = (COND_CYCLES > AUTO_CYCLES) ? COND_CYCLES : AUTO_CYCLES;
  localparam int CW = $clog2(MAXC + 1);
  localparam seq_state_e FAULT_NEXT = AUTO_RECOVER ? SQ_AUTO : SQ_FAULT;

  seq_state_e    st_q;
  logic [CW-1:0] cnt_q;

  assign busy     = (st_q == SQ_ARMED) || (st_q == SQ_CLEAN);
  assign run      = st_q == SQ_RUN;
  assign seed_hit = seed_evt && !busy && !crst_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SQ_RUN;
      cnt_q  <= '0;
      secs   <= 1'b0;
      reseed <= 1'b0;
    end else begin
      reseed <= 1'b0;
      case (st_q)
        SQ_RUN: begin
          if (crst_set) st_q <= SQ_ARMED;
          else if (seed_evt) begin
            st_q  <= FAULT_NEXT;
            secs  <= 1'b1;
            cnt_q <= '0;
          end
        end
        SQ_FAULT: if (crst_set) st_q <= SQ_ARMED;
        SQ_AUTO: begin
          if (crst_set) st_q <= SQ_ARMED;
          else if (cnt_q == CW'(AUTO_CYCLES - 1)) begin
            st_q <= SQ_RUN;
            secs <= 1'b0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        SQ_ARMED: begin
          if (crst_clr) begin
            st_q  <= SQ_CLEAN;
            cnt_q <= '0;
          end
        end
        SQ_CLEAN: begin
          if (cnt_q == CW'(COND_CYCLES - 1)) begin
            st_q   <= SQ_RUN;
            secs   <= 1'b0;
            reseed <= 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= SQ_RUN;
      endcase
    end
  end
endmodule

// File: rtl/rand_src_front.sv
module rand_src_front
  import rng_front_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int COND_CYCLES = 16,
  parameter int AUTO_CYCLES = 32,
  parameter bit AUTO_RECOVER = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              seed_fault,
  input  logic              clk_fault
);
  logic [DATA_W-1:0]  cfg_q;
  logic               en_q;
  logic [NOISE_W-1:0] ns_q;
  logic [DATA_W-1:0]  ht_q;
  logic               seis_q, ceis_q, cecs_q;
  logic               seed_fault_q;
  logic [DATA_W-1:0]  rd_mux;

  logic wr_hit, rd_hit, wr_ctrl, wr_stat, cfg_open;
  logic crst_set, crst_clr, seed_evt;
  logic seq_busy, seq_run, seq_secs, seq_hit, seq_reseed;
  logic gen_push, fifo_pop, fifo_empty, fifo_full, drdy;
  logic [DATA_W-1:0] gen_word, fifo_dout, seed_val;

  assign wr_hit   = bus_sel && bus_wr;
  assign rd_hit   = bus_sel && !bus_wr;
  assign wr_ctrl  = wr_hit && (bus_addr == A_CTRL);
  assign wr_stat  = wr_hit && (bus_addr == A_STAT);
  assign crst_set = wr_ctrl && bus_wdata[B_CRST];
  assign crst_clr = wr_ctrl && !bus_wdata[B_CRST] && seq_busy;
  assign cfg_open = seq_busy && !cfg_q[B_LOCK];
  assign seed_evt = seed_fault && !seed_fault_q;
  assign seed_val = (ht_q ^ DATA_W'(ns_q)) | DATA_W'(1);
  assign drdy     = !fifo_empty && !seq_secs;
  assign fifo_pop = rd_hit && (bus_addr == A_DATA) && drdy;

  rng_seq_ctrl #(
    .COND_CYCLES(COND_CYCLES),
    .AUTO_CYCLES(AUTO_CYCLES),
    .AUTO_RECOVER(AUTO_RECOVER)
  ) u_seq (
    .clk(clk), .rst(rst), .crst_set(crst_set), .crst_clr(crst_clr),
    .seed_evt(seed_evt), .busy(seq_busy), .run(seq_run), .secs(seq_secs),
    .seed_hit(seq_hit), .reseed(seq_reseed)
  );

  rng_lfsr_gen #(.W(DATA_W), .DW(DIV_W)) u_gen (
    .clk(clk), .rst(rst), .div_exp(cfg_q[B_DIV +: DIV_W]), .reseed(seq_reseed),
    .seed(seed_val), .allow(seq_run && en_q), .room(!fifo_full),
    .push(gen_push), .word(gen_word)
  );

  rng_word_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(!seq_run), .push(gen_push), .din(gen_word),
    .pop(fifo_pop), .dout(fifo_dout), .empty(fifo_empty), .full(fifo_full)
  );

  // control, noise and health registers
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      en_q  <= 1'b0;
      ns_q  <= '0;
      ht_q  <= '0;
    end else begin
      if (wr_ctrl) en_q <= bus_wdata[B_EN];
      if (crst_set && !cfg_q[B_LOCK]) cfg_q <= bus_wdata & CFG_MASK;
      if (wr_hit && cfg_open && bus_addr == A_NOISE) ns_q <= bus_wdata[NOISE_W-1:0];
      if (wr_hit && cfg_open && bus_addr == A_HTEST) ht_q <= bus_wdata;
    end
  end

  // fault tracking
  always_ff @(posedge clk) begin
    if (rst) begin
      seed_fault_q <= 1'b0;
      cecs_q       <= 1'b0;
      ceis_q       <= 1'b0;
      seis_q       <= 1'b0;
    end else begin
      seed_fault_q <= seed_fault;
      cecs_q       <= clk_fault && cfg_q[B_CED];
      if (cecs_q) ceis_q <= 1'b1;
      else if (wr_stat && !bus_wdata[S_CSTKY]) ceis_q <= 1'b0;
      if (seq_hit) seis_q <= 1'b1;
      else if (seq_reseed) seis_q <= 1'b0;
      else if (wr_stat && !bus_wdata[S_SSTKY]) seis_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CTRL: begin
        rd_mux         = cfg_q;
        rd_mux[B_CRST] = seq_busy;
        rd_mux[B_EN]   = en_q;
      end
      A_STAT: begin
        rd_mux[S_RDY]   = drdy;
        rd_mux[S_CLIVE] = cecs_q;
        rd_mux[S_SLIVE] = seq_secs;
        rd_mux[S_CSTKY] = ceis_q;
        rd_mux[S_SSTKY] = seis_q;
      end
      A_DATA:  rd_mux = drdy ? fifo_dout : '0;
      A_NOISE: rd_mux = DATA_W'(ns_q);
      A_HTEST: rd_mux = ht_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd_hit) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/rand_src_front_chk.sv
module rand_src_front_chk (
  input logic        clk,
  input logic        rst,
  input logic        secs,
  input logic        seis,
  input logic        fifo_empty,
  input logic [31:0] cfg,
  input logic        pop,
  input logic        push,
  input logic [31:0] push_word,
  input logic        busy,
  input logic        reseed
);
  AST_FAULT_DRAINS: assert property (@(posedge clk) disable iff (rst) secs |=> fifo_empty); // R8
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst) $rose(secs) |-> seis); // R8
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst) cfg[31] |=> (cfg[31] && $stable(cfg))); // R5
  AST_NO_EMPTY_POP: assert property (@(posedge clk) disable iff (rst) pop |-> !fifo_empty); // R7
  AST_WORD_NONZERO: assert property (@(posedge clk) disable iff (rst) push |-> (push_word != 32'h0)); // R6
  AST_RESEED_ON_EXIT: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> reseed); // R4
endmodule

bind rand_src_front rand_src_front_chk u_chk (
  .clk(clk), .rst(rst), .secs(seq_secs), .seis(seis_q), .fifo_empty(fifo_empty),
  .cfg(cfg_q), .pop(fifo_pop), .push(gen_push), .push_word(gen_word),
  .busy(seq_busy), .reseed(seq_reseed)
);

// File: tb/rand_src_front_bench.sv
`timescale 1ns/1ps
module rand_src_front_bench;
  localparam int DEPTH = 4;
  localparam int COND = 6;
  localparam int AUTOC = 10;
  localparam logic [31:0] POLY = 32'hB4BC_D35C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic        sel [2];
  logic        wr [2];
  logic [4:0]  addr [2];
  logic [31:0] wdata [2];
  logic [31:0] rdata [2];
  logic        sfault [2];
  logic        cfault [2];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rand_src_front #(.FIFO_DEPTH(DEPTH), .COND_CYCLES(COND), .AUTO_CYCLES(AUTOC), .AUTO_RECOVER(1'b0))
    u_rand_src_front (.clk(clk), .rst(rst), .bus_sel(sel[0]), .bus_wr(wr[0]), .bus_addr(addr[0]),
      .bus_wdata(wdata[0]), .bus_rdata(rdata[0]), .seed_fault(sfault[0]), .clk_fault(cfault[0]));

  rand_src_front #(.FIFO_DEPTH(DEPTH), .COND_CYCLES(COND), .AUTO_CYCLES(AUTOC), .AUTO_RECOVER(1'b1))
    u_rand_src_front_auto (.clk(clk), .rst(rst), .bus_sel(sel[1]), .bus_wr(wr[1]), .bus_addr(addr[1]),
      .bus_wdata(wdata[1]), .bus_rdata(rdata[1]), .seed_fault(sfault[1]), .clk_fault(cfault[1]));

  typedef struct packed {
    logic        w;
    logic [4:0]  a;
    logic [31:0] d;
    logic [31:0] e;
    logic [3:0]  r;
  } vec_t;

  localparam vec_t VEC [15] = '{
    '{1'b0, 5'h00, 32'h0, 32'h0, 4'd1},                       // R1 control
    '{1'b0, 5'h04, 32'h0, 32'h0, 4'd1},                       // R1 status
    '{1'b0, 5'h08, 32'h0, 32'h0, 4'd7},                       // R7 not ready reads 0
    '{1'b0, 5'h0C, 32'h0, 32'h0, 4'd1},                       // R1 noise
    '{1'b1, 5'h00, 32'h0000_0F00, 32'h0, 4'd3},               // R3 write without reset bit
    '{1'b0, 5'h00, 32'h0, 32'h0, 4'd3},                       // R3 ignored
    '{1'b1, 5'h0C, 32'h0003_FFFF, 32'h0, 4'd4},               // R4 noise closed
    '{1'b0, 5'h0C, 32'h0, 32'h0, 4'd4},                       // R4 still zero
    '{1'b1, 5'h00, 32'h4000_0F20, 32'h0, 4'd3},               // R3 capture with reset bit
    '{1'b0, 5'h00, 32'h0, 32'h4000_0F20, 4'd4},               // R4 bit 30 held
    '{1'b1, 5'h0C, 32'hFFFF_FFFF, 32'h0, 4'd2},               // R2 noise write
    '{1'b0, 5'h0C, 32'h0, 32'h0003_FFFF, 4'd2},               // R2 18 bits kept
    '{1'b1, 5'h10, 32'h0000_1234, 32'h0, 4'd2},               // R2 health write
    '{1'b0, 5'h10, 32'h0, 32'h0000_1234, 4'd2},               // R2 health readback
    '{1'b0, 5'h14, 32'h0, 32'h0, 4'd1}                        // R1 unmapped
  };

  function automatic logic [31:0] step(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ POLY) : (s >> 1);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input int i, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    sel[i] = 1'b1; wr[i] = 1'b1; addr[i] = a; wdata[i] = d;
    @(negedge clk);
    sel[i] = 1'b0; wr[i] = 1'b0;
  endtask

  task automatic bus_read(input int i, input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    sel[i] = 1'b1; wr[i] = 1'b0; addr[i] = a;
    @(negedge clk);
    sel[i] = 1'b0;
    d = rdata[i];
  endtask

  task automatic pulse_seed(input int i);
    @(negedge clk);
    sfault[i] = 1'b1;
    @(negedge clk);
    sfault[i] = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] seed;
    logic [31:0] w;
    logic [31:0] first;
    for (int i = 0; i < 2; i++) begin
      sel[i] = 0; wr[i] = 0; addr[i] = 0; wdata[i] = 0; sfault[i] = 0; cfault[i] = 0;
    end
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // table walk on the held-fault copy
    for (int k = 0; k < 15; k++) begin
      if (VEC[k].w) bus_write(0, VEC[k].a, VEC[k].d);
      else begin
        bus_read(0, VEC[k].a, rd);
        check($sformatf("R%0d vector %0d", VEC[k].r, k), rd, VEC[k].e);
      end
    end

    // R4 release and self-clear
    bus_write(0, 5'h00, 32'h0000_0F24);
    bus_read(0, 5'h00, rd);
    check("R4 bit 30 during cleaning", rd, 32'h4000_0F24);
    repeat (12) @(posedge clk);
    bus_read(0, 5'h00, rd);
    check("R4 bit 30 self-cleared", rd, 32'h0000_0F24);

    // R6 word order after reseed
    seed = (32'h0000_1234 ^ 32'h0003_FFFF) | 32'h1;
    repeat (30) @(posedge clk);
    bus_read(0, 5'h04, rd);
    check("R7 ready with full queue", rd, 32'h0000_0001);
    w = seed;
    for (int n = 0; n < 6; n++) begin
      w = step(w);
      if (n == 0) first = w;
      bus_read(0, 5'h08, rd);
      check($sformatf("R6 word %0d", n), rd, w);
    end

    // R12 clock fault, R11 flag clear
    repeat (10) @(posedge clk);
    @(negedge clk); cfault[0] = 1'b1;
    repeat (3) @(posedge clk);
    bus_read(0, 5'h04, rd);
    check("R12 clock fault live", rd, 32'h0000_0023);
    @(negedge clk); cfault[0] = 1'b0;
    repeat (3) @(posedge clk);
    bus_read(0, 5'h04, rd);
    check("R12 clock fault latched", rd, 32'h0000_0021);
    bus_write(0, 5'h04, 32'hFFFF_FFDF);
    bus_read(0, 5'h04, rd);
    check("R11 clear bit 5 only", rd, 32'h0000_0001);

    // R8 seed fault, R9 held without auto restart
    pulse_seed(0);
    repeat (3) @(posedge clk);
    bus_read(0, 5'h04, rd);
    check("R8 seed fault flags", rd, 32'h0000_0044);
    bus_read(0, 5'h08, rd);
    check("R8 data reads zero", rd, 32'h0);
    repeat (30) @(posedge clk);
    bus_read(0, 5'h04, rd);
    check("R9 live flag held", rd, 32'h0000_0044);

    // R5 lock with R13 divider 4, R9 recovery
    bus_write(0, 5'h00, 32'hC004_0F24);
    bus_write(0, 5'h10, 32'h0000_00A5);
    bus_read(0, 5'h10, rd);
    check("R5 health write blocked", rd, 32'h0000_1234);
    bus_write(0, 5'h00, 32'h8004_0F24);
    repeat (12) @(posedge clk);
    bus_read(0, 5'h04, rd);
    check("R9 flags cleared, R13 not yet ready", rd, 32'h0);
    repeat (40) @(posedge clk);
    bus_read(0, 5'h04, rd);
    check("R13 ready after divided tick", rd, 32'h0000_0001);
    bus_read(0, 5'h08, rd);
    check("R9 reseeded first word", rd, first);
    bus_write(0, 5'h00, 32'h4000_0000);
    bus_read(0, 5'h00, rd);
    check("R5 config kept under lock", rd, 32'hC004_0F20);
    bus_write(0, 5'h00, 32'h0000_0004);
    repeat (12) @(posedge clk);
    bus_read(0, 5'h00, rd);
    check("R5 lock stays after reset", rd, 32'h8004_0F24);

    // auto-restart copy: R6 reset seed, R10
    bus_write(1, 5'h00, 32'h0000_0004);
    repeat (10) @(posedge clk);
    bus_read(1, 5'h08, rd);
    check("R6 first word from reset seed", rd, POLY);
    pulse_seed(1);
    repeat (3) @(posedge clk);
    bus_read(1, 5'h04, rd);
    check("R8 auto copy fault flags", rd, 32'h0000_0044);
    repeat (AUTOC + 10) @(posedge clk);
    bus_read(1, 5'h04, rd);
    check("R10 restarted, sticky kept", rd, 32'h0000_0041);
    bus_write(1, 5'h04, 32'h0);
    bus_read(1, 5'h04, rd);
    check("R10 sticky cleared by write", rd, 32'h0000_0001);
    bus_read(1, 5'h08, rd);
    check("R10 data flows again", {31'h0, rd != 32'h0}, 32'h1);

    finish_run();
  end
endmodule